// File: doc/BRIEF.md
# Paged Data Address Generator

This block forms the byte addresses a processor datapath uses to reach data memory. It has two generators that work independently, one for loads and one for stores. Each generator takes a pointer value from the register file, an addressing-mode code, an operand-size flag, an immediate address field and an 8-bit page value. From these it produces a 24-bit extended byte address and the pointer value that goes back to the register file.

The 16-bit effective address names one byte, so the base space is 64 KB. The page value is placed above it, which widens the reach to 16 MB. Loads use the load page and stores use the store page. In the post-modify modes the pointer moves by the operand size: 1 for a byte, 2 for a word. A strobe tells the register file to take the updated pointer back. In the short near-direct mode only a 13-bit field is used, which reaches the first 8 KB of the page.

Each generator registers its result, so outputs appear one clock after a request is presented.

Top module: `paged_agu`

## Requirements
- R1: While reset (`rst_n` low) is held and just after it, every output reads zero: valid flags, write-back strobes, addresses and updated pointers.
- R2: Mode codes 0 (register indirect), 1 (post-increment) and 2 (post-decrement) use the incoming pointer as the effective address: the address equals {page, ptr}, one clock after the request.
- R3: Mode 1 sets the updated pointer to ptr+1 when the byte flag is 1 and to ptr+2 when it is 0, wrapping modulo 2^16.
- R4: Mode 2 sets the updated pointer to ptr-1 for a byte and ptr-2 for a word, wrapping modulo 2^16.
- R5: The write-back strobe is high exactly one clock after a request with mode 1 or 2, and low after any other mode or after no request.
- R6: Mode 3 (memory direct) uses the full 16-bit immediate as the effective address and returns the pointer unchanged.
- R7: Mode 4 (near direct) uses immediate bits [12:0], zero-extended, as the effective address. Immediate bits [15:13] are ignored and the pointer is returned unchanged.
- R8: Address bits [23:16] come from `rd_page` for the load side and from `wr_page` for the store side. Both sides accept requests in the same cycle without affecting each other.
- R9: With no request, the side's valid flag and strobe go low the next clock. Its address and updated pointer keep their previous values.
- R10: Reserved mode codes 5, 6 and 7 behave as register indirect, with the pointer unchanged and no write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_req | input | 1 | Load-side request |
| rd_mode | input | 3 | Load-side addressing mode code |
| rd_byte | input | 1 | Load-side operand is a byte (1) or a word (0) |
| rd_ptr | input | 16 | Load-side pointer register value |
| rd_imm | input | 16 | Load-side immediate address field |
| rd_page | input | 8 | Load page value |
| wr_req | input | 1 | Store-side request |
| wr_mode | input | 3 | Store-side addressing mode code |
| wr_byte | input | 1 | Store-side operand is a byte (1) or a word (0) |
| wr_ptr | input | 16 | Store-side pointer register value |
| wr_imm | input | 16 | Store-side immediate address field |
| wr_page | input | 8 | Store page value |
| rd_vld | output | 1 | Load-side result valid |
| rd_addr | output | 24 | Load-side extended byte address |
| rd_ptr_nxt | output | 16 | Load-side updated pointer |
| rd_wb | output | 1 | Load-side pointer write-back strobe |
| wr_vld | output | 1 | Store-side result valid |
| wr_addr | output | 24 | Store-side extended byte address |
| wr_ptr_nxt | output | 16 | Store-side updated pointer |
| wr_wb | output | 1 | Store-side pointer write-back strobe |

## Verification
The assertions relate each registered output to the inputs one cycle earlier. They take for granted that the inputs are steady and known at every rising edge once reset has been released, and they assume nothing about which mode codes appear. The bench changes inputs only on falling edges. It draws every mode code, including the reserved ones, with random pointers, immediates and pages, so that all input values stay known. It adds directed cases that sit the pointer at 0x0000, 0x0001, 0xFFFE and 0xFFFF to reach the wrap points.

// File: rtl/paged_agu.sv
module paged_agu #(
  parameter int EA_W = 16,
  parameter int PG_W = 8,
  parameter int NEAR_W = 13
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_req,
  input  logic [2:0]           rd_mode,
  input  logic                 rd_byte,
  input  logic [EA_W-1:0]      rd_ptr,
  input  logic [EA_W-1:0]      rd_imm,
  input  logic [PG_W-1:0]      rd_page,
  input  logic                 wr_req,
  input  logic [2:0]           wr_mode,
  input  logic                 wr_byte,
  input  logic [EA_W-1:0]      wr_ptr,
  input  logic [EA_W-1:0]      wr_imm,
  input  logic [PG_W-1:0]      wr_page,
  output logic                 rd_vld,
  output logic [PG_W+EA_W-1:0] rd_addr,
  output logic [EA_W-1:0]      rd_ptr_nxt,
  output logic                 rd_wb,
  output logic                 wr_vld,
  output logic [PG_W+EA_W-1:0] wr_addr,
  output logic [EA_W-1:0]      wr_ptr_nxt,
  output logic                 wr_wb
);
  localparam int XW = PG_W + EA_W;
  localparam logic [2:0] M_IND = 3'd0, M_INC = 3'd1, M_DEC = 3'd2,
                         M_DIR = 3'd3, M_NEAR = 3'd4;

  function automatic logic [EA_W-1:0] f_ea(input logic [2:0] m,
      input logic [EA_W-1:0] p, input logic [EA_W-1:0] imm);
    case (m)
      M_DIR:   f_ea = imm;
      M_NEAR:  f_ea = {{(EA_W-NEAR_W){1'b0}}, imm[NEAR_W-1:0]};
      default: f_ea = p;
    endcase
  endfunction

  function automatic logic [EA_W-1:0] f_upd(input logic [2:0] m,
      input logic b, input logic [EA_W-1:0] p);
    logic [EA_W-1:0] step;
    step = b ? EA_W'(1) : EA_W'(2);
    case (m)
      M_INC:   f_upd = p + step;
      M_DEC:   f_upd = p - step;
      default: f_upd = p;
    endcase
  endfunction

  wire rd_post = (rd_mode == M_INC) || (rd_mode == M_DEC);
  wire wr_post = (wr_mode == M_INC) || (wr_mode == M_DEC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld     <= 1'b0;
      rd_wb      <= 1'b0;
      rd_addr    <= '0;
      rd_ptr_nxt <= '0;
    end else begin
      rd_vld <= rd_req;
      rd_wb  <= rd_req && rd_post;
      if (rd_req) begin
        rd_addr    <= XW'({rd_page, f_ea(rd_mode, rd_ptr, rd_imm)});
        rd_ptr_nxt <= f_upd(rd_mode, rd_byte, rd_ptr);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_vld     <= 1'b0;
      wr_wb      <= 1'b0;
      wr_addr    <= '0;
      wr_ptr_nxt <= '0;
    end else begin
      wr_vld <= wr_req;
      wr_wb  <= wr_req && wr_post;
      if (wr_req) begin
        wr_addr    <= XW'({wr_page, f_ea(wr_mode, wr_ptr, wr_imm)});
        wr_ptr_nxt <= f_upd(wr_mode, wr_byte, wr_ptr);
      end
    end
  end
endmodule

// File: rtl/paged_agu_chk.sv
module paged_agu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_req,
  input logic [2:0]  rd_mode,
  input logic        rd_byte,
  input logic [15:0] rd_ptr,
  input logic [15:0] rd_imm,
  input logic [7:0]  rd_page,
  input logic        wr_req,
  input logic [2:0]  wr_mode,
  input logic        wr_byte,
  input logic [15:0] wr_ptr,
  input logic [15:0] wr_imm,
  input logic [7:0]  wr_page,
  input logic        rd_vld,
  input logic [23:0] rd_addr,
  input logic [15:0] rd_ptr_nxt,
  input logic        rd_wb,
  input logic        wr_vld,
  input logic [23:0] wr_addr,
  input logic [15:0] wr_ptr_nxt,
  input logic        wr_wb
);
  // R5
  rd_wb_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> rd_wb == ($past(rd_req) && ($past(rd_mode) == 3'd1 || $past(rd_mode) == 3'd2)));
  // R5
  wr_wb_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> wr_wb == ($past(wr_req) && ($past(wr_mode) == 3'd1 || $past(wr_mode) == 3'd2)));
  // R8
  rd_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && rd_vld |-> rd_addr[23:16] == $past(rd_page));
  // R8
  wr_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && wr_vld |-> wr_addr[23:16] == $past(wr_page));
  // R3
  rd_inc_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(rd_req) && $past(rd_mode) == 3'd1 && $past(rd_byte)
    |-> rd_ptr_nxt == $past(rd_ptr) + 16'd1);
  // R4
  wr_dec_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(wr_req) && $past(wr_mode) == 3'd2 && !$past(wr_byte)
    |-> wr_ptr_nxt == $past(wr_ptr) - 16'd2);
  // R6
  rd_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(rd_req) && $past(rd_mode) == 3'd3 |-> rd_addr[15:0] == $past(rd_imm));
  // R7
  wr_near_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(wr_req) && $past(wr_mode) == 3'd4
    |-> wr_addr[15:0] == {3'b000, $past(wr_imm[12:0])});
  // R9
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(rd_req) |-> !rd_vld && $stable(rd_addr) && $stable(rd_ptr_nxt));
  // R9
  wr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(wr_req) |-> !wr_vld && $stable(wr_addr) && $stable(wr_ptr_nxt));
endmodule

bind paged_agu paged_agu_chk u_chk (.*);

// File: tb/sim_paged_agu.sv
`timescale 1ns/1ps
module sim_paged_agu;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rd_req = 0, wr_req = 0, rd_byte = 0, wr_byte = 0;
  logic [2:0] rd_mode = 0, wr_mode = 0;
  logic [15:0] rd_ptr = 0, wr_ptr = 0, rd_imm = 0, wr_imm = 0;
  logic [7:0] rd_page = 0, wr_page = 0;
  logic rd_vld, wr_vld, rd_wb, wr_wb;
  logic [23:0] rd_addr, wr_addr;
  logic [15:0] rd_ptr_nxt, wr_ptr_nxt;
  int errors = 0, checks = 0;
  logic [57:0] e_rd = '0, e_wr = '0;

  always #2.5 clk = ~clk;

  paged_agu u0 (.*);

  function automatic logic [15:0] m_ea(input logic [2:0] m, input logic [15:0] p, input logic [15:0] i);
    if (m == 3'd3) return i;
    if (m == 3'd4) return {3'b000, i[12:0]};
    return p;
  endfunction

  function automatic logic [15:0] m_ptr(input logic [2:0] m, input logic b, input logic [15:0] p);
    if (m == 3'd1) return b ? p + 16'd1 : p + 16'd2;
    if (m == 3'd2) return b ? p - 16'd1 : p - 16'd2;
    return p;
  endfunction

  // {vld, wb, addr, ptr_nxt}
  function automatic logic [57:0] m_out(input logic [57:0] prev, input logic q, input logic [2:0] m,
      input logic b, input logic [15:0] p, input logic [15:0] i, input logic [7:0] pg);
    if (!q) return {2'b00, prev[39:16], prev[15:0]};
    return {1'b1, (m == 3'd1 || m == 3'd2), pg, m_ea(m, p, i), m_ptr(m, b, p)};
  endfunction

  function automatic string tag(input logic q, input logic [2:0] m);
    if (!q) return "R9";
    case (m)
      3'd0: return "R2";
      3'd1: return "R3/R5";
      3'd2: return "R4/R5";
      3'd3: return "R6";
      3'd4: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string t, input logic [57:0] act, input logic [57:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", t, act, exp);
    end
  endtask

  task automatic step();
    string trd, twr;
    trd = tag(rd_req, rd_mode);
    twr = tag(wr_req, wr_mode);
    e_rd = m_out(e_rd, rd_req, rd_mode, rd_byte, rd_ptr, rd_imm, rd_page);
    e_wr = m_out(e_wr, wr_req, wr_mode, wr_byte, wr_ptr, wr_imm, wr_page);
    @(posedge clk);
    @(negedge clk);
    check({"rd ", trd, " R8"}, {rd_vld, rd_wb, rd_addr, rd_ptr_nxt}, e_rd);
    check({"wr ", twr, " R8"}, {wr_vld, wr_wb, wr_addr, wr_ptr_nxt}, e_wr);
  endtask

  task automatic set_rd(input logic q, input logic [2:0] m, input logic b, input logic [15:0] p,
      input logic [15:0] i, input logic [7:0] pg);
    rd_req = q; rd_mode = m; rd_byte = b; rd_ptr = p; rd_imm = i; rd_page = pg;
  endtask

  task automatic set_wr(input logic q, input logic [2:0] m, input logic b, input logic [15:0] p,
      input logic [15:0] i, input logic [7:0] pg);
    wr_req = q; wr_mode = m; wr_byte = b; wr_ptr = p; wr_imm = i; wr_page = pg;
  endtask

  initial begin : wd
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog act=hung exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'h5EED_1234;
    void'($urandom(seed));
    // R1: reset state with requests pending
    set_rd(1, 3'd1, 0, 16'h1234, 16'h5678, 8'hAB);
    repeat (3) @(negedge clk);
    check("R1 rd reset", {rd_vld, rd_wb, rd_addr, rd_ptr_nxt}, 58'd0);
    check("R1 wr reset", {wr_vld, wr_wb, wr_addr, wr_ptr_nxt}, 58'd0);
    set_rd(0, 0, 0, 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {rd_vld, rd_wb, rd_addr, rd_ptr_nxt, wr_vld, wr_wb, wr_addr, wr_ptr_nxt}[57:0], 58'd0);

    // R3 wrap points
    set_rd(1, 3'd1, 1, 16'hFFFF, 0, 8'h12); set_wr(1, 3'd1, 0, 16'hFFFE, 0, 8'h34); step();
    // R4 wrap points
    set_rd(1, 3'd2, 1, 16'h0000, 0, 8'h56); set_wr(1, 3'd2, 0, 16'h0001, 0, 8'h78); step();
    // R6 full field, R7 upper immediate bits ignored
    set_rd(1, 3'd3, 0, 16'hAAAA, 16'hFFFF, 8'hFF); set_wr(1, 3'd4, 1, 16'h5555, 16'hFFFF, 8'h01); step();
    set_rd(1, 3'd4, 0, 16'h0102, 16'hE000, 8'h9C); set_wr(1, 3'd3, 0, 16'h0304, 16'h2000, 8'h00); step();
    // R10 reserved codes, R9 idle hold
    set_rd(1, 3'd7, 0, 16'h4444, 16'h1111, 8'h44); set_wr(0, 3'd1, 0, 16'h9999, 0, 8'h99); step();
    set_rd(0, 3'd2, 1, 16'h7777, 0, 8'h77); set_wr(1, 3'd6, 1, 16'h2222, 0, 8'h22); step();
    // R2 plain indirect, R8 distinct pages at once
    set_rd(1, 3'd0, 1, 16'hBEEF, 16'h0000, 8'hC3); set_wr(1, 3'd0, 0, 16'hBEEF, 16'h0000, 8'h3C); step();

    for (int n = 0; n < 400; n++) begin
      set_rd(($urandom % 5) != 0, 3'($urandom), 1'($urandom), 16'($urandom), 16'($urandom), 8'($urandom));
      set_wr(($urandom % 5) != 0, 3'($urandom), 1'($urandom), 16'($urandom), 16'($urandom), 8'($urandom));
      step();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule